// File: doc/BRIEF.md
# Processor Operating Mode Controller

This block keeps track of which operating mode a processor core is in and moves it between modes on each clock edge. It watches five control levels (protection enable, the virtual-legacy flag, paging enable, the long-mode enable bit and the long bit of the current code segment) and two event pulses: a system-management request and a resume from system-management mode. From these it produces a 3-bit mode code, a long-mode-active status bit and the mode that was saved when system-management mode was last entered.

There are six mode codes. Real-address mode is 0, protected mode is 1 and virtual-legacy mode is 2. Long mode has two sub-modes: 64-bit is 3 and compatibility is 4. System-management mode (SMM) is 5. Codes 6 and 7 are never produced.

Neighbouring logic decodes the mode code to decide how addresses are formed and which instructions are legal. The block does not decode instructions, save context to memory or translate addresses.

Top module: `opmode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the mode is real-address (0), the saved mode is 0 and the long-active bit is 0.
- R2: From real-address mode, a set protection-enable bit moves the mode to protected (1) on the next clock edge. From protected mode, a clear protection-enable bit moves it back to real-address (0).
- R3: In protected mode, a set virtual flag moves the mode to virtual-legacy (2). In virtual-legacy mode, clearing the flag returns to protected (1), and clearing protection enable returns to real-address (0).
- R4: In protected mode with paging and long-mode enable both set, the next mode is long mode and the long-active bit becomes 1. The code-segment long bit picks the sub-mode: set gives 64-bit (3) and clear gives compatibility (4).
- R5: In long mode, a change of the code-segment long bit switches between 64-bit (3) and compatibility (4) on the next edge.
- R6: In long mode, clearing paging or long-mode enable returns the mode to protected (1) and clears the long-active bit.
- R7: In long mode, a set virtual flag has no effect: the mode stays in its long sub-mode.
- R8: A request pulse in any mode other than SMM moves the mode to SMM (5) on the next edge. The saved mode then holds the code of the mode that was active, and the long-active bit still shows whether that saved mode was a long mode.
- R9: A resume pulse in SMM returns the mode to exactly the saved mode on the next edge.
- R10: A request that arrives while already in SMM is held. After the resume, the core spends one cycle in the saved mode and then re-enters SMM, saving that mode again. No nested save takes place.
- R11: A resume pulse outside SMM is ignored: the mode and the saved mode do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_en_i | input | 1 | Protection enable control bit |
| virt_flag_i | input | 1 | Virtual-legacy mode flag |
| paging_en_i | input | 1 | Paging enable |
| long_en_i | input | 1 | Long-mode enable bit |
| cs_long_i | input | 1 | Long bit of the current code segment |
| smi_req_i | input | 1 | System-management request pulse |
| smi_resume_i | input | 1 | Resume-from-SMM pulse |
| mode_o | output | MODE_W | Current mode code |
| long_active_o | output | 1 | Long mode active status |
| saved_mode_o | output | MODE_W | Mode captured on SMM entry |

## Verification
The hardest case to reach is a request that arrives while the block is already in SMM. The request must be held internally and must not overwrite the saved mode. The bench enters SMM from protected mode and pulses the request a second time inside SMM. It then resumes and checks two consecutive cycles: the first in protected mode, the second back in SMM with protected mode saved again. The long-mode cases are reached by first settling in protected mode with the virtual flag clear, because long mode can only be entered from protected mode.

// File: rtl/opmode_pkg.sv
package opmode_pkg;

   typedef enum logic [2:0] {
      OM_REAL   = 3'd0,
      OM_PROT   = 3'd1,
      OM_VIRT   = 3'd2,
      OM_L64    = 3'd3,
      OM_COMPAT = 3'd4,
      OM_SMM    = 3'd5
   } opmode_e;

   typedef struct packed {
      logic prot_en;
      logic virt;
      logic paging;
      logic long_en;
      logic cs_long;
   } mode_ctrl_t;

   function automatic logic is_long(opmode_e m);
      return (m == OM_L64) || (m == OM_COMPAT);
   endfunction

endpackage

// File: rtl/opmode_next.sv
module opmode_next
   import opmode_pkg::*;
(
   input  opmode_e    cur_i,
   input  mode_ctrl_t ctrl_i,
   output opmode_e    nxt_o
);
   opmode_e long_sub;

   always_comb begin
      long_sub = ctrl_i.cs_long ? OM_L64 : OM_COMPAT;
      unique case (cur_i)
         OM_REAL:   nxt_o = ctrl_i.prot_en ? OM_PROT : OM_REAL;
         OM_PROT: begin
            if (!ctrl_i.prot_en)                        nxt_o = OM_REAL;
            else if (ctrl_i.paging && ctrl_i.long_en)   nxt_o = long_sub;
            else if (ctrl_i.virt)                       nxt_o = OM_VIRT;
            else                                        nxt_o = OM_PROT;
         end
         OM_VIRT: begin
            if (!ctrl_i.prot_en)    nxt_o = OM_REAL;
            else if (!ctrl_i.virt)  nxt_o = OM_PROT;
            else                    nxt_o = OM_VIRT;
         end
         OM_L64, OM_COMPAT: begin
            if (!ctrl_i.paging || !ctrl_i.long_en) nxt_o = OM_PROT;
            else                                   nxt_o = long_sub;
         end
         OM_SMM:    nxt_o = OM_SMM;
         default:   nxt_o = OM_REAL;
      endcase
   end
endmodule

// File: rtl/opmode_smm_seq.sv
module opmode_smm_seq
   import opmode_pkg::*;
#(
   parameter bit HOLD_NESTED = 1'b1
)(
   input  logic    clk,
   input  logic    rst_n,
   input  opmode_e cur_i,
   input  logic    req_i,
   input  logic    resume_i,
   output logic    take_o,
   output logic    leave_o,
   output opmode_e saved_o
);
   logic in_smm;
   logic pend_q;

   assign in_smm  = (cur_i == OM_SMM);
   assign take_o  = !in_smm && (req_i || pend_q);
   assign leave_o = in_smm && resume_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      saved_o <= OM_REAL;
      else if (take_o) saved_o <= cur_i;
   end

   generate
      if (HOLD_NESTED) begin : g_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= in_smm && (pend_q || req_i);
         end
      end else begin : g_drop
         assign pend_q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/opmode_ctrl.sv
module opmode_ctrl
   import opmode_pkg::*;
#(
   parameter int MODE_W      = 3,
   parameter bit HOLD_NESTED = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_en_i,
   input  logic              virt_flag_i,
   input  logic              paging_en_i,
   input  logic              long_en_i,
   input  logic              cs_long_i,
   input  logic              smi_req_i,
   input  logic              smi_resume_i,
   output logic [MODE_W-1:0] mode_o,
   output logic              long_active_o,
   output logic [MODE_W-1:0] saved_mode_o
);
   localparam int CODE_W = $bits(opmode_e);

   generate
      if (MODE_W != CODE_W) begin : g_bad_width
         $error("opmode_ctrl: MODE_W must equal the mode code width");
      end
   endgenerate

   opmode_e    mode_q, mode_d, ctrl_nxt, saved;
   mode_ctrl_t ctrl;
   logic       take, leave;

   assign ctrl = '{prot_en: prot_en_i, virt: virt_flag_i, paging: paging_en_i,
                   long_en: long_en_i, cs_long: cs_long_i};

   opmode_next u_next (
      .cur_i  (mode_q),
      .ctrl_i (ctrl),
      .nxt_o  (ctrl_nxt)
   );

   opmode_smm_seq #(.HOLD_NESTED(HOLD_NESTED)) u_smm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cur_i    (mode_q),
      .req_i    (smi_req_i),
      .resume_i (smi_resume_i),
      .take_o   (take),
      .leave_o  (leave),
      .saved_o  (saved)
   );

   always_comb begin
      if (take)                  mode_d = OM_SMM;
      else if (leave)            mode_d = saved;
      else if (mode_q == OM_SMM) mode_d = OM_SMM;
      else                       mode_d = ctrl_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= OM_REAL;
      else        mode_q <= mode_d;
   end

   assign mode_o        = mode_q;
   assign saved_mode_o  = saved;
   assign long_active_o = is_long(mode_q) || ((mode_q == OM_SMM) && is_long(saved));
endmodule

// File: rtl/opmode_ctrl_chk.sv
module opmode_ctrl_chk #(
   parameter int MODE_W = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              smi_req_i,
   input logic              smi_resume_i,
   input logic              virt_flag_i,
   input logic [MODE_W-1:0] mode_o,
   input logic [MODE_W-1:0] saved_mode_o,
   input logic              long_active_o
);
   localparam logic [MODE_W-1:0] C_REAL = 0;
   localparam logic [MODE_W-1:0] C_VIRT = 2;
   localparam logic [MODE_W-1:0] C_L64  = 3;
   localparam logic [MODE_W-1:0] C_CMP  = 4;
   localparam logic [MODE_W-1:0] C_SMM  = 5;

   a_r1_reset_real: assert property (@(posedge clk)
      !rst_n |=> (mode_o == C_REAL) || rst_n);

   a_r8_smi_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (smi_req_i && mode_o != C_SMM) |=>
         (mode_o == C_SMM) && (saved_mode_o == $past(mode_o)));

   a_r9_resume_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == C_SMM && smi_resume_i) |=> (mode_o == $past(saved_mode_o)));

   a_r7_virt_ignored_long: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_o == C_L64 || mode_o == C_CMP) && virt_flag_i) |=> (mode_o != C_VIRT));

   a_r11_saved_only_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != C_SMM) |=> ((mode_o == C_SMM) || $stable(saved_mode_o)));

   a_r6_active_tracks_long: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != C_SMM) |-> (long_active_o == (mode_o == C_L64 || mode_o == C_CMP)));

   a_r10_no_nested_save: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == C_SMM && !smi_resume_i) |=> $stable(saved_mode_o));
endmodule

bind opmode_ctrl opmode_ctrl_chk #(.MODE_W(MODE_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .smi_req_i     (smi_req_i),
   .smi_resume_i  (smi_resume_i),
   .virt_flag_i   (virt_flag_i),
   .mode_o        (mode_o),
   .saved_mode_o  (saved_mode_o),
   .long_active_o (long_active_o)
);

// File: tb/tb_opmode_ctrl.sv
`timescale 1ns/1ps
module tb_opmode_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prot_en = 0, virt = 0, paging = 0, long_en = 0, cs_long = 0;
   logic smi = 0, resume = 0;
   logic [2:0] mode, saved;
   logic active;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   opmode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .prot_en_i(prot_en), .virt_flag_i(virt),
      .paging_en_i(paging), .long_en_i(long_en), .cs_long_i(cs_long),
      .smi_req_i(smi), .smi_resume_i(resume),
      .mode_o(mode), .long_active_o(active), .saved_mode_o(saved)
   );

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic pulse_smi();
      smi = 1; tick(); smi = 0;
   endtask

   task automatic pulse_resume();
      resume = 1; tick(); resume = 0;
   endtask

   task automatic go_real();
      prot_en = 0; virt = 0; paging = 0; long_en = 0; cs_long = 0; tick(); tick();
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1 mode in reset", mode, 0);
      rst_n = 1; tick();
      check("R1 mode after reset", mode, 0);
      check("R1 saved after reset", saved, 0);
      check("R1 active after reset", active, 0);
   endtask

   task automatic t_real_prot();
      prot_en = 1; tick();
      check("R2 real->prot", mode, 1);
      prot_en = 0; tick();
      check("R2 prot->real", mode, 0);
   endtask

   task automatic t_virt();
      prot_en = 1; tick();
      virt = 1; tick();
      check("R3 prot->virt", mode, 2);
      virt = 0; tick();
      check("R3 virt->prot", mode, 1);
      virt = 1; tick();
      prot_en = 0; tick();
      check("R3 virt->real", mode, 0);
      go_real();
   endtask

   task automatic t_long();
      prot_en = 1; tick();
      paging = 1; long_en = 1; cs_long = 1; tick();
      check("R4 enter 64-bit", mode, 3);
      check("R4 active set", active, 1);
      cs_long = 0; tick();
      check("R5 to compat", mode, 4);
      cs_long = 1; tick();
      check("R5 to 64-bit", mode, 3);
      virt = 1; tick();
      check("R7 virt ignored", mode, 3);
      tick();
      check("R7 virt still ignored", mode, 3);
      virt = 0; paging = 0; tick();
      check("R6 paging off", mode, 1);
      check("R6 active cleared", active, 0);
      paging = 1; cs_long = 0; tick();
      check("R4 enter compat", mode, 4);
      long_en = 0; tick();
      check("R6 enable off", mode, 1);
      check("R6 active cleared again", active, 0);
      go_real();
   endtask

   task automatic t_smi();
      pulse_smi();
      check("R8 smi from real", mode, 5);
      check("R8 saved real", saved, 0);
      prot_en = 1;
      pulse_resume();
      check("R9 back to real", mode, 0);
      tick();
      check("R2 prot after resume", mode, 1);
      paging = 1; long_en = 1; cs_long = 0; tick();
      pulse_smi();
      check("R8 smi from compat", mode, 5);
      check("R8 saved compat", saved, 4);
      check("R8 active kept in smm", active, 1);
      tick(); tick();
      check("R8 stays in smm", mode, 5);
      pulse_resume();
      check("R9 back to compat", mode, 4);
      go_real();
   endtask

   task automatic t_nested();
      prot_en = 1; tick();
      pulse_smi();
      check("R8 smi from prot", mode, 5);
      pulse_smi();
      check("R10 second smi stays", mode, 5);
      check("R10 saved untouched", saved, 1);
      pulse_resume();
      check("R10 one cycle in prot", mode, 1);
      tick();
      check("R10 re-entered smm", mode, 5);
      check("R10 saved prot again", saved, 1);
      pulse_resume();
      check("R9 resume to prot", mode, 1);
      tick();
      check("R10 no further entry", mode, 1);
   endtask

   task automatic t_resume_ignored();
      pulse_resume();
      check("R11 mode unchanged", mode, 1);
      check("R11 saved unchanged", saved, 1);
      go_real();
      pulse_resume();
      check("R11 real unchanged", mode, 0);
   endtask

   initial begin
      t_reset();
      t_real_prot();
      t_virt();
      t_long();
      t_smi();
      t_nested();
      t_resume_ignored();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule